// File: doc/BRIEF.md
# Multifunction Pin Controller with Gated-Input Edge Interrupt

This block governs a single multifunction I/O pin. A small register set, loaded over a synchronous write bus, selects what drives the pin. The pin can act as a plain software-controlled port. It can carry the serial data output of alternate function A. It can carry the I2C clock of alternate function B. A separate bit turns the output stage into an N-channel open-drain driver. The pad is represented by an output-enable and an output-data signal, and the sampled pad level comes back in as an input.

The returning pin level first passes through a two-flop synchronizer, which also serves as the port input register. It is then ANDed with the alternate-mode bit before it reaches alternate-function logic. Because of that gating, turning on alternate mode while the pin sits high looks like a low-to-high transition. An edge detector on the gated signal raises a one-cycle interrupt for each selected edge. The detector faithfully reports that false edge. Software avoids it by enabling edge selection only after the mode switch.

Top module: `pin_mux_ctrl`

## Requirements
- R1: After a cycle with rst_n low on a clock edge, every register is 0. pin_oe, irq and af_in are all 0.
- R2: With the alternate-mode bit (address 0, bit 0) at 0, pin_oe follows the port direction bit and pin_out follows the port data bit. The direction bit is at address 1, bit 0, where 1 means output. The data bit is at address 1, bit 1. With direction 0 the pin is Hi-Z (pin_oe = 0).
- R3: With alternate mode 1 and the function-select bit (address 0, bit 1) at 0, the pin is driven (pin_oe = 1) with pin_out equal to sdo_a.
- R4: With alternate mode 1, function select 1 and the open-drain bit (address 0, bit 2) at 0, the pin is driven with pin_out equal to scl_b. A high clock is actively driven high.
- R5: With the open-drain bit at 1, a high output value gives pin_oe = 0 and a low output value gives pin_oe = 1 with pin_out = 0.
- R6: port_rd shows pin_in as it was two rising clock edges earlier.
- R7: af_in equals port_rd ANDed with the alternate-mode bit, so it is 0 whenever alternate mode is 0.
- R8: The edge select is the two low bits at address 2: 00 none, 01 rising, 10 falling, 11 both. Each selected transition of af_in between consecutive cycles gives irq high for exactly the one cycle in which the new af_in value first appears.
- R9: Suppose the pin is high and rising detection is already selected. Setting alternate mode from 0 to 1 raises irq in the cycle right after the write.
- R10: The previous-value register of the detector updates every cycle, even with edge select 00. Selecting rising edges after alternate mode is already 1, with the pin steadily high, gives no irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| pin_in | input | 1 | Sampled pad level |
| sdo_a | input | 1 | Serial data from alternate function A |
| scl_b | input | 1 | I2C clock value from alternate function B |
| pin_oe | output | 1 | Pad output enable |
| pin_out | output | 1 | Pad output data |
| port_rd | output | 1 | Synchronized pin level (port input register) |
| af_in | output | 1 | Gated level delivered to alternate-function logic |
| irq | output | 1 | One-cycle edge interrupt pulse |

## Verification
Register writes land on the clock edge that samples wr_en. Pin drive (R2 to R5), af_in and a mode-change interrupt (R9) are therefore due in the cycle right after that edge. A pin_in change is seen on port_rd, af_in and irq only after the second rising edge (R6, R8). The irq pulse is gone one edge later. Inputs change on falling edges and outputs are sampled on falling edges exactly at those counted cycles, with extra checks one cycle early and one cycle late to pin down the latency and pulse width.

// File: rtl/pmc_pkg.sv
// Shared types and register addresses for the multifunction pin controller.
// Assumes a 2-bit address space and 8-bit write data.
package pmc_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_EDGE = 2'd2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic      alt_en;
        logic      func_b;
        logic      od_en;
        logic      port_dir;
        logic      port_dout;
        edge_sel_e esel;
    } pmc_cfg_t;

endpackage

// File: rtl/pmc_cfg_regs.sv
// Configuration register file.
// It decodes single-cycle writes into the mode, port and edge-select fields.
// Assumes write data is valid in the same cycle as wr_en; the reset is synchronous active-low.
module pmc_cfg_regs
    import pmc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output pmc_cfg_t      cfg
);

    // Register update: clear on reset, load the addressed field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE: begin
                    cfg.alt_en <= wr_data[0];
                    cfg.func_b <= wr_data[1];
                    cfg.od_en  <= wr_data[2];
                end
                ADDR_PORT: begin
                    cfg.port_dir  <= wr_data[0];
                    cfg.port_dout <= wr_data[1];
                end
                ADDR_EDGE: cfg.esel <= edge_sel_e'(wr_data[1:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pmc_out_mux.sv
// Output selection for the pad.
// It chooses between port, function A data and function B clock, then applies open-drain masking.
// Purely combinational; assumes the configuration is already registered.
module pmc_out_mux
    import pmc_pkg::*;
(
    input  pmc_cfg_t cfg,
    input  logic     sdo_a,
    input  logic     scl_b,
    output logic     pin_oe,
    output logic     pin_out
);

    logic drv_en;
    logic drv_val;

    // Source selection by mode and function select.
    always_comb begin
        if (!cfg.alt_en) begin
            drv_en  = cfg.port_dir;
            drv_val = cfg.port_dout;
        end else if (!cfg.func_b) begin
            drv_en  = 1'b1;
            drv_val = sdo_a;
        end else begin
            drv_en  = 1'b1;
            drv_val = scl_b;
        end
    end

    // Open-drain stage: a high value releases the pad.
    always_comb begin
        pin_out = drv_val;
        pin_oe  = drv_en & ~(cfg.od_en & drv_val);
    end

endmodule

// File: rtl/pmc_in_gate.sv
// Input path: synchronizes the pad level through a chain of flops.
// The last flop doubles as the port input register.
// The synchronized level is then ANDed with the alternate-mode bit.
// Assumes STAGES >= 2.
module pmc_in_gate #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic alt_en,
    output logic sync_lvl,
    output logic gated
);

    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // First stage samples the asynchronous pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= pin_in;
            end
        end else begin : g_next
            // Later stages shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    // Gate toward alternate-function logic.
    always_comb begin
        sync_lvl = stage_q[STAGES-1];
        gated    = sync_lvl & alt_en;
    end

endmodule

// File: rtl/pmc_edge_det.sv
// Edge detector on the gated input.
// The previous-value flop updates every cycle regardless of edge selection.
// irq is combinational from registered state, so it lasts exactly one cycle per edge.
module pmc_edge_det
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  edge_sel_e esel,
    output logic      irq
);

    logic prev_q;

    // History flop, always tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Qualify rise and fall against the selection bits.
    always_comb begin
        irq = (esel[0] & lvl & ~prev_q) | (esel[1] & ~lvl & prev_q);
    end

endmodule

// File: rtl/pin_mux_ctrl.sv
// Top level of the multifunction pin controller.
// It ties together the register file, output mux, input gating and edge interrupt.
// Assumes a single clock and a synchronous active-low reset.
module pin_mux_ctrl
    import pmc_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          pin_in,
    input  logic          sdo_a,
    input  logic          scl_b,
    output logic          pin_oe,
    output logic          pin_out,
    output logic          port_rd,
    output logic          af_in,
    output logic          irq
);

    pmc_cfg_t cfg_q;

    pmc_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg_q)
    );

    pmc_out_mux u_mux (
        .cfg     (cfg_q),
        .sdo_a   (sdo_a),
        .scl_b   (scl_b),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    pmc_in_gate #(.STAGES(SYNC_STAGES)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .alt_en   (cfg_q.alt_en),
        .sync_lvl (port_rd),
        .gated    (af_in)
    );

    pmc_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (af_in),
        .esel  (cfg_q.esel),
        .irq   (irq)
    );

endmodule

// File: rtl/pmc_checker.sv
// Property checker for pin_mux_ctrl, attached with bind below.
module pmc_checker
    import pmc_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     pin_oe,
    input logic     pin_out,
    input logic     port_rd,
    input logic     af_in,
    input logic     irq,
    input pmc_cfg_t cfg
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!pin_oe && !irq && !af_in));

    // R7
    gate_subset_chk: assert property (@(posedge clk) disable iff (!rst_n) af_in |-> port_rd);

    // R4
    scl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.alt_en && cfg.func_b && !cfg.od_en) |-> pin_oe);

    // R5
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.od_en && pin_out) |-> !pin_oe);

    // R8
    irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (af_in != $past(af_in)));

    // R10
    none_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.esel == EDGE_NONE) |-> !irq);

endmodule

bind pin_mux_ctrl pmc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_oe  (pin_oe),
    .pin_out (pin_out),
    .port_rd (port_rd),
    .af_in   (af_in),
    .irq     (irq),
    .cfg     (cfg_q)
);

// File: tb/tb_pin_mux_ctrl.sv
// Directed bench for pin_mux_ctrl: one task per scenario, each checking its own results.
module tb_pin_mux_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pin_in = 1'b0;
    logic       sdo_a = 1'b0;
    logic       scl_b = 1'b0;
    logic       pin_oe, pin_out, port_rd, af_in, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    pin_mux_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_in(pin_in), .sdo_a(sdo_a), .scl_b(scl_b), .pin_oe(pin_oe), .pin_out(pin_out),
        .port_rd(port_rd), .af_in(af_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Write one register; fields are updated when this returns (on a falling edge).
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        check("R1", "pin_oe", pin_oe, 1'b0);
        check("R1", "irq", irq, 1'b0);
        check("R1", "af_in", af_in, 1'b0);
    endtask

    task automatic t_port;
        check("R2", "hiz dir0", pin_oe, 1'b0);
        wr(2'd1, 8'b10);
        check("R2", "hiz dir0 data1", pin_oe, 1'b0);
        wr(2'd1, 8'b11);
        check("R2", "oe dir1", pin_oe, 1'b1);
        check("R2", "out data1", pin_out, 1'b1);
        wr(2'd1, 8'b01);
        check("R2", "out data0", pin_out, 1'b0);
    endtask

    task automatic t_serial;
        wr(2'd0, 8'b001);
        sdo_a = 1'b1; #1;
        check("R3", "oe", pin_oe, 1'b1);
        check("R3", "out hi", pin_out, 1'b1);
        sdo_a = 1'b0; #1;
        check("R3", "out lo", pin_out, 1'b0);
    endtask

    task automatic t_i2c;
        wr(2'd0, 8'b011);
        scl_b = 1'b1; #1;
        check("R4", "push-pull high oe", pin_oe, 1'b1);
        check("R4", "push-pull high out", pin_out, 1'b1);
        scl_b = 1'b0; #1;
        check("R4", "low out", pin_out, 1'b0);
    endtask

    task automatic t_od;
        wr(2'd0, 8'b111);
        scl_b = 1'b1; #1;
        check("R5", "high released", pin_oe, 1'b0);
        scl_b = 1'b0; #1;
        check("R5", "low driven oe", pin_oe, 1'b1);
        check("R5", "low driven out", pin_out, 1'b0);
        wr(2'd0, 8'b000);
    endtask

    task automatic t_sync_gate;
        @(negedge clk);
        pin_in = 1'b1;
        @(negedge clk);
        check("R6", "one edge not yet", port_rd, 1'b0);
        @(negedge clk);
        check("R6", "two edges", port_rd, 1'b1);
        check("R7", "gated off mode0", af_in, 1'b0);
    endtask

    // Pin high, rising selected first, then mode on: false edge expected.
    task automatic t_hazard;
        wr(2'd2, 8'b01);
        check("R9", "no irq before mode", irq, 1'b0);
        wr(2'd0, 8'b001);
        check("R7", "gated on mode1", af_in, 1'b1);
        check("R9", "irq on mode switch", irq, 1'b1);
        @(negedge clk);
        check("R8", "pulse one cycle", irq, 1'b0);
    endtask

    // Safe ordering: mode first, edge select after.
    task automatic t_safe;
        wr(2'd2, 8'b00);
        wr(2'd0, 8'b000);
        check("R10", "mode off no irq", irq, 1'b0);
        wr(2'd0, 8'b001);
        check("R10", "mode on with none", irq, 1'b0);
        wr(2'd2, 8'b01);
        check("R10", "rise enabled late", irq, 1'b0);
        @(negedge clk);
        check("R10", "still quiet", irq, 1'b0);
    endtask

    task automatic t_fall_both;
        wr(2'd2, 8'b10);
        @(negedge clk);
        pin_in = 1'b0;
        @(negedge clk);
        check("R8", "fall early", irq, 1'b0);
        @(negedge clk);
        check("R8", "fall irq", irq, 1'b1);
        @(negedge clk);
        check("R8", "fall ends", irq, 1'b0);
        wr(2'd2, 8'b11);
        pin_in = 1'b1;
        idle(2);
        check("R8", "both rise", irq, 1'b1);
        pin_in = 1'b0;
        idle(2);
        check("R8", "both fall", irq, 1'b1);
        wr(2'd2, 8'b10);
        pin_in = 1'b1;
        idle(2);
        check("R8", "rise ignored in fall mode", irq, 1'b0);
    endtask

    initial begin
        t_reset();
        t_port();
        t_serial();
        t_i2c();
        t_od();
        t_sync_gate();
        t_hazard();
        t_safe();
        t_fall_both();
        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule